// File: doc/BRIEF.md
# Converter Output Word Serializer

This block is the digital output stage of a bridge-sensor delta-sigma converter. A filter-cycle timer counts master clocks and marks the end of each conversion. At that moment the block takes the conversion sample and the overrange indication from its stimulus ports. It builds a 24-bit output word from a data field followed by a run of identical flag bits. A host clocks the word out, MSB first, using a serial clock and an active-low frame select. Both host signals are sampled in the master clock domain.

The data field is 16 or 20 bits wide. The sample arrives as straight (offset) binary. Unipolar mode passes it through unchanged. Bipolar mode turns it into two's complement by inverting its top bit. An overrange forces the field to the full-scale code of the active coding and sets every flag bit. The first word after reset or after a wake strobe also carries set flags.

A data-ready line reports a fresh, unread word. A conversion that completes during a read is held back until the frame ends, so the word being read never changes. A settled output stays low for a fixed number of words after reset, wake, a timer restart or a disturbance strobe (input step, gain change or calibration change). Several devices can be aligned with a sync strobe. After the strobe, the filter timer restarts on the 24th falling serial-clock edge of the next frame.

Top module: `cnv_word_serializer`

## Requirements
- R1: `drdy_n_o` falls once every `CYCLES_PER_WORD` master clocks while the filter timer runs undisturbed and each word is read out in full before the next one completes.
- R2: With `wide_i`=0 the word is {data[15:0], eight flag bits}. With `wide_i`=1 it is {data[19:0], four flag bits}. In 16-bit mode the data comes from `sample_i[15:0]`. All flag bits in a word are equal and are 0 in normal operation.
- R3: With `bipolar_i`=0 the data field equals the sample. With `bipolar_i`=1 it equals the sample with its top data bit inverted, so offset code 0x8000 becomes 0x0000 in 16-bit mode.
- R4: When `ovr_i`=1 at word completion, every flag bit is 1 and the data field saturates. With `ovr_neg_i`=0 it takes positive full scale: all ones when unipolar, 0x7FFF / 0x7FFFF when bipolar. With `ovr_neg_i`=1 it takes negative full scale: zero when unipolar, 0x8000 / 0x80000 when bipolar.
- R5: The first word completed after reset, or after a `wake_i` strobe, has all flag bits set. Its data field is formatted normally.
- R6: Inside a frame (`cs_n_i`=0), `sdo_o` presents word bit 23 first. Each falling edge of `sclk_i` advances it by one bit toward bit 0. After 24 falling edges `sdo_o` reads 0.
- R7: `drdy_n_o` is 1 after reset. It goes 0 when a new word is loaded into the output register. It returns to 1 on the 24th falling `sclk_i` edge of a frame.
- R8: A word that completes while a frame is open does not change the word being read. It is loaded when the frame closes, and `drdy_n_o` then goes 0.
- R9: A frame may end after fewer than 24 bits. The next frame starts again at bit 23 of the same word, and `drdy_n_o` stays 0.
- R10: After a `sync_arm_i` strobe, the 24th falling `sclk_i` edge of a frame restarts the filter timer from zero. The next word then completes `CYCLES_PER_WORD` clocks later, plus a fixed latency of a few clocks.
- R11: `settled_o` is 0 after reset. It is forced to 0 by `disturb_i`, `wake_i` or a timer restart. It becomes 1 only when the `SETTLE_WORDS`-th word after that event completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_i | input | 20 | Conversion sample, offset binary |
| ovr_i | input | 1 | Overrange present at word completion |
| ovr_neg_i | input | 1 | Overrange direction, 1 = negative |
| bipolar_i | input | 1 | 1 = two's complement coding |
| wide_i | input | 1 | 1 = 20-bit data, 0 = 16-bit data |
| disturb_i | input | 1 | Strobe: input step, gain or calibration change |
| wake_i | input | 1 | Strobe: exit from sleep |
| sync_arm_i | input | 1 | Strobe: arm timer restart on next 24th falling edge |
| sclk_i | input | 1 | Host serial clock, idles high |
| cs_n_i | input | 1 | Host frame select, active low |
| sdo_o | output | 1 | Serial data out |
| drdy_n_o | output | 1 | Data ready, active low |
| settled_o | output | 1 | Output has settled |

## Verification
The assertions assume that `sclk_i` and `cs_n_i` are slow compared with `clk`, so each level lasts several master clocks through the synchronizer. They also assume that the stimulus inputs are steady at the clock where a word completes. The bench holds each serial-clock half period for eight master clocks and opens and closes frames only while `sclk_i` is high. It changes the sample, coding and overrange inputs only just after a word has been read, well before the next completion. Strobes are single-cycle pulses driven between frames, except for the sync strobe, which is issued just before the frame that carries the restart.

// File: rtl/cws_pkg.sv
package cws_pkg;
  localparam int WORD_W   = 24;
  localparam int DATA_MAX = 20;
  localparam int DATA_MIN = 16;
  localparam int IDX_W    = $clog2(WORD_W + 1);
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/cws_timer.sv
module cws_timer #(
  parameter int CYCLES_PER_WORD = 81920
) (
  input  logic clk,
  input  logic rst,
  input  logic restart_i,
  output logic tick_o
);
  localparam int CNT_W = $clog2(CYCLES_PER_WORD);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES_PER_WORD - 1);

  logic [CNT_W-1:0] count;

  always_ff @(posedge clk) begin
    if (rst) begin
      count  <= '0;
      tick_o <= 1'b0;
    end else if (restart_i) begin
      count  <= '0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= (count == LAST);
      count  <= (count == LAST) ? '0 : count + CNT_W'(1);
    end
  end

  p_count_range_r1: assert property (@(posedge clk) disable iff (rst)
    count <= LAST);
  p_tick_single_r1: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o);
endmodule

// File: rtl/cws_fmt.sv
module cws_fmt
  import cws_pkg::*;
(
  input  logic [DATA_MAX-1:0] sample_i,
  input  logic                ovr_i,
  input  logic                ovr_neg_i,
  input  logic                bipolar_i,
  input  logic                wide_i,
  input  logic                force_flag_i,
  output word_t               word_o
);
  localparam int FLAG_WIDE   = WORD_W - DATA_MAX;
  localparam int FLAG_NARROW = WORD_W - DATA_MIN;

  logic [DATA_MAX-1:0] d_wide;
  logic [DATA_MIN-1:0] d_narrow;
  logic                flag;

  always_comb begin
    flag = ovr_i | force_flag_i;
    if (ovr_i) begin
      d_wide   = ovr_neg_i ? '0 : '1;
      d_narrow = ovr_neg_i ? '0 : '1;
    end else begin
      d_wide   = sample_i;
      d_narrow = sample_i[DATA_MIN-1:0];
    end
    if (bipolar_i) begin
      d_wide[DATA_MAX-1]   = ~d_wide[DATA_MAX-1];
      d_narrow[DATA_MIN-1] = ~d_narrow[DATA_MIN-1];
    end
    if (wide_i) word_o = {d_wide, {FLAG_WIDE{flag}}};
    else        word_o = {d_narrow, {FLAG_NARROW{flag}}};
  end
endmodule

// File: rtl/cws_settle.sv
module cws_settle #(
  parameter int SETTLE_WORDS = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic disturb_i,
  input  logic wake_i,
  input  logic restart_i,
  output logic fresh_o,
  output logic settled_o
);
  localparam int SC_W = $clog2(SETTLE_WORDS + 1);
  localparam logic [SC_W-1:0] FULL = SC_W'(SETTLE_WORDS);

  logic [SC_W-1:0] cnt, cnt_next;
  logic            clear;

  always_comb begin
    clear = disturb_i | wake_i | restart_i;
    if (clear)                      cnt_next = '0;
    else if (tick_i && cnt != FULL) cnt_next = cnt + SC_W'(1);
    else                            cnt_next = cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      settled_o <= 1'b0;
      fresh_o   <= 1'b1;
    end else begin
      cnt       <= cnt_next;
      settled_o <= (cnt_next == FULL);
      if (wake_i)      fresh_o <= 1'b1;
      else if (tick_i) fresh_o <= 1'b0;
    end
  end

  p_clear_unsettled_r11: assert property (@(posedge clk) disable iff (rst)
    (disturb_i || wake_i || restart_i) |=> !settled_o);
  p_settle_on_word_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(settled_o) |-> $past(tick_i));
endmodule

// File: rtl/cws_shift.sv
module cws_shift
  import cws_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  sclk_i,
  input  logic  cs_n_i,
  input  logic  tick_i,
  input  word_t word_i,
  input  logic  sync_arm_i,
  output logic  sdo_o,
  output logic  drdy_n_o,
  output logic  restart_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_W - 1);
  localparam logic [IDX_W-1:0] END_IDX  = IDX_W'(WORD_W);

  logic [2:0]       sclk_q, csn_q;
  logic             fall_w, frame_w, end_w;
  word_t            out_word, pend_word;
  logic             pend_v, armed;
  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= '1;
      csn_q  <= '1;
    end else begin
      sclk_q <= {sclk_q[1:0], sclk_i};
      csn_q  <= {csn_q[1:0], cs_n_i};
    end
  end

  assign fall_w  = sclk_q[2] & ~sclk_q[1];
  assign frame_w = ~csn_q[1];
  assign end_w   = csn_q[1] & ~csn_q[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      out_word  <= '0;
      pend_word <= '0;
      pend_v    <= 1'b0;
      idx       <= '0;
      drdy_n_o  <= 1'b1;
      armed     <= 1'b0;
      restart_o <= 1'b0;
      sdo_o     <= 1'b0;
    end else begin
      restart_o <= 1'b0;
      if (end_w) begin
        idx <= '0;
        if (pend_v) begin
          out_word <= pend_word;
          pend_v   <= 1'b0;
          drdy_n_o <= 1'b0;
        end
      end else if (frame_w && fall_w && idx < END_IDX) begin
        idx <= idx + IDX_W'(1);
        if (idx == LAST_IDX) begin
          drdy_n_o <= 1'b1;
          if (armed) begin
            restart_o <= 1'b1;
            armed     <= 1'b0;
          end
        end
      end
      if (sync_arm_i) armed <= 1'b1;
      if (tick_i) begin
        if (frame_w) begin
          pend_word <= word_i;
          pend_v    <= 1'b1;
        end else begin
          out_word <= word_i;
          pend_v   <= 1'b0;
          drdy_n_o <= 1'b0;
        end
      end
      sdo_o <= (idx < END_IDX) ? out_word[LAST_IDX - idx] : 1'b0;
    end
  end

  p_word_stable_r8: assert property (@(posedge clk) disable iff (rst)
    frame_w |=> $stable(out_word));
  p_idx_bound_r6: assert property (@(posedge clk) disable iff (rst)
    idx <= END_IDX);
  p_drdy_release_r7: assert property (@(posedge clk) disable iff (rst)
    (frame_w && fall_w && idx == LAST_IDX) |=> drdy_n_o);
endmodule

// File: rtl/cnv_word_serializer.sv
module cnv_word_serializer
  import cws_pkg::*;
#(
  parameter int CYCLES_PER_WORD = 81920,
  parameter int SETTLE_WORDS    = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [DATA_MAX-1:0] sample_i,
  input  logic                ovr_i,
  input  logic                ovr_neg_i,
  input  logic                bipolar_i,
  input  logic                wide_i,
  input  logic                disturb_i,
  input  logic                wake_i,
  input  logic                sync_arm_i,
  input  logic                sclk_i,
  input  logic                cs_n_i,
  output logic                sdo_o,
  output logic                drdy_n_o,
  output logic                settled_o
);
  logic  tick, restart, fresh;
  word_t word;

  cws_timer #(.CYCLES_PER_WORD(CYCLES_PER_WORD)) u_timer (
    .clk(clk), .rst(rst), .restart_i(restart), .tick_o(tick));

  cws_settle #(.SETTLE_WORDS(SETTLE_WORDS)) u_settle (
    .clk(clk), .rst(rst), .tick_i(tick), .disturb_i(disturb_i),
    .wake_i(wake_i), .restart_i(restart), .fresh_o(fresh),
    .settled_o(settled_o));

  cws_fmt u_fmt (
    .sample_i(sample_i), .ovr_i(ovr_i), .ovr_neg_i(ovr_neg_i),
    .bipolar_i(bipolar_i), .wide_i(wide_i), .force_flag_i(fresh),
    .word_o(word));

  cws_shift u_shift (
    .clk(clk), .rst(rst), .sclk_i(sclk_i), .cs_n_i(cs_n_i),
    .tick_i(tick), .word_i(word), .sync_arm_i(sync_arm_i),
    .sdo_o(sdo_o), .drdy_n_o(drdy_n_o), .restart_o(restart));

  p_first_word_flags_r5: assert property (@(posedge clk) disable iff (rst)
    (tick && fresh) |-> (word[0] && word[3]));
endmodule

// File: tb/cnv_word_serializer_tb.sv
module cnv_word_serializer_tb;
  localparam int CYC = 1000;
  localparam int SET = 6;

  logic        clk = 0, rst = 1;
  logic [19:0] sample = 0;
  logic        ovr = 0, ovr_neg = 0, bip = 0, wide = 0;
  logic        disturb = 0, wake = 0, sync_arm = 0;
  logic        sclk = 1, cs_n = 1;
  logic        sdo, drdy_n, settled;

  int tests = 0, fails = 0;
  int cyc = 0, fall_cyc = 0, last_edge_cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cnv_word_serializer #(.CYCLES_PER_WORD(CYC), .SETTLE_WORDS(SET)) u_dut (
    .clk(clk), .rst(rst), .sample_i(sample), .ovr_i(ovr), .ovr_neg_i(ovr_neg),
    .bipolar_i(bip), .wide_i(wide), .disturb_i(disturb), .wake_i(wake),
    .sync_arm_i(sync_arm), .sclk_i(sclk), .cs_n_i(cs_n), .sdo_o(sdo),
    .drdy_n_o(drdy_n), .settled_o(settled));

  function automatic logic [23:0] exp_word(logic [19:0] s, logic o, logic on,
                                           logic b, logic w, logic f);
    logic [19:0] d20;
    logic [15:0] d16;
    logic fl;
    fl  = o | f;
    d20 = o ? (on ? 20'h0 : 20'hFFFFF) : s;
    d16 = o ? (on ? 16'h0 : 16'hFFFF) : s[15:0];
    if (b) begin d20[19] = ~d20[19]; d16[15] = ~d16[15]; end
    return w ? {d20, {4{fl}}} : {d16, {8{fl}}};
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_drdy();
    int n = 0;
    @(negedge clk);
    while (drdy_n !== 1'b0 && n < 5000) begin @(negedge clk); n++; end
    fall_cyc = cyc;
  endtask

  task automatic read_bits(int n, output logic [31:0] w);
    w = '0;
    cs_n = 0;
    idle(8);
    for (int b = 0; b < n; b++) begin
      w[31-b] = sdo;
      sclk = 0;
      last_edge_cyc = cyc;
      idle(8);
      sclk = 1;
      idle(8);
    end
    cs_n = 1;
    idle(8);
  endtask

  task automatic set_in(logic [19:0] s, logic o, logic on, logic b, logic w);
    sample = s; ovr = o; ovr_neg = on; bip = b; wide = w;
  endtask

  task automatic pulse(ref logic sig);
    sig = 1; idle(1); sig = 0;
  endtask

  initial begin
    idle(190000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [23:0] e, e2;
    int prev;
    void'($urandom(32'd5516));
    idle(5);
    rst = 0;
    idle(2);
    check(drdy_n == 1 && settled == 0 && sdo == 0, "R7 R11 reset state",
          {drdy_n, settled, sdo}, 3'b100);

    // R5 first word after reset carries flags
    set_in(20'h12345, 0, 0, 0, 0);
    wait_drdy();
    prev = fall_cyc;
    read_bits(24, rd);
    check(rd[31:8] == exp_word(20'h12345, 0, 0, 0, 0, 1), "R5 first word flags",
          rd[31:8], exp_word(20'h12345, 0, 0, 0, 0, 1));
    check(drdy_n == 1, "R7 drdy released after 24 bits", drdy_n, 1);

    // directed corners then random words
    for (int k = 0; k < 26; k++) begin
      logic [19:0] s; logic o, on, b, w;
      case (k)
        0: begin s = 20'h08000; o = 0; on = 0; b = 1; w = 0; end
        1: begin s = 20'h00000; o = 1; on = 0; b = 1; w = 0; end
        2: begin s = 20'hFFFFF; o = 1; on = 1; b = 1; w = 1; end
        3: begin s = 20'h00001; o = 1; on = 1; b = 0; w = 0; end
        4: begin s = 20'h00000; o = 1; on = 0; b = 0; w = 1; end
        5: begin s = 20'h80000; o = 0; on = 0; b = 1; w = 1; end
        default: begin
          s = 20'($urandom); o = ($urandom % 4) == 0; on = 1'($urandom);
          b = 1'($urandom); w = 1'($urandom);
        end
      endcase
      set_in(s, o, on, b, w);
      wait_drdy();
      check(fall_cyc - prev == CYC, "R1 word period", fall_cyc - prev, CYC);
      prev = fall_cyc;
      read_bits(24, rd);
      e = exp_word(s, o, on, b, w, 0);
      check(rd[31:8] == e, o ? "R4 overrange word" : (b ? "R3 bipolar word" : "R2 unipolar word"),
            rd[31:8], e);
    end
    check(settled == 1, "R11 settled after many words", settled, 1);

    // R6 bits beyond 24 read zero; R9 partial read restarts at MSB
    set_in(20'hA5C3F, 0, 0, 0, 1);
    e = exp_word(20'hA5C3F, 0, 0, 0, 1, 0);
    wait_drdy();
    read_bits(8, rd);
    check(rd[31:24] == e[23:16], "R9 partial read top bits", rd[31:24], e[23:16]);
    check(drdy_n == 0, "R9 drdy held after partial read", drdy_n, 0);
    read_bits(26, rd);
    check(rd[31:8] == e, "R9 reread from MSB", rd[31:8], e);
    check(rd[7:6] == 2'b00, "R6 bits past 24 are zero", rd[7:6], 0);

    // R8 completion during an open frame is buffered
    set_in(20'h13579, 0, 0, 1, 1);
    wait_drdy();
    e  = exp_word(20'h13579, 0, 0, 1, 1, 0);
    set_in(20'h2468A, 1, 0, 0, 0);
    e2 = exp_word(20'h2468A, 1, 0, 0, 0, 0);
    cs_n = 0;
    idle(1050);
    read_bits(24, rd);
    check(rd[31:8] == e, "R8 word stable across completion", rd[31:8], e);
    check(drdy_n == 0, "R8 buffered word presented", drdy_n, 0);
    read_bits(24, rd);
    check(rd[31:8] == e2, "R8 buffered word content", rd[31:8], e2);

    // R10 sync restart on 24th falling edge
    set_in(20'h0F0F0, 0, 0, 0, 0);
    wait_drdy();
    pulse(sync_arm);
    read_bits(24, rd);
    check(settled == 0, "R11 unsettled after restart", settled, 0);
    wait_drdy();
    check(fall_cyc - last_edge_cyc >= CYC && fall_cyc - last_edge_cyc <= CYC + 8,
          "R10 timer restart", fall_cyc - last_edge_cyc, CYC);
    read_bits(24, rd);

    // R11 disturbance needs SET words to settle
    pulse(disturb);
    idle(2);
    check(settled == 0, "R11 cleared by disturbance", settled, 0);
    for (int k = 1; k <= SET; k++) begin
      wait_drdy();
      check(settled == (k >= SET), "R11 settle count", settled, k >= SET);
      read_bits(24, rd);
    end

    // R5 wake forces flags on next word
    set_in(20'h00400, 0, 0, 1, 0);
    pulse(wake);
    wait_drdy();
    read_bits(24, rd);
    e = exp_word(20'h00400, 0, 0, 1, 0, 1);
    check(rd[31:8] == e, "R5 flags after wake", rd[31:8], e);
    wait_drdy();
    read_bits(24, rd);
    e = exp_word(20'h00400, 0, 0, 1, 0, 0);
    check(rd[31:8] == e, "R5 flags cleared on second word", rd[31:8], e);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule